// File: doc/BRIEF.md
# Interleaved Thread Issue Scheduler with Memory Lookahead

This block picks, on every clock, at most one hardware context out of a large pool to issue its next instruction. A context may issue only if its instruction is present, if enough cycles have passed since its own previous issue, and if it is not held back by an outstanding memory reference. The issue stage of an interleaved multithreaded core uses it. The block sees only a memory flag and a 3-bit lookahead count for each context's head instruction; the rest of the instruction is outside it.

Each context runs a small state machine. `CTX_FREE` means no memory reference is outstanding. A memory issue from `CTX_FREE` loads the lookahead counter from the instruction's tag. It goes to `CTX_AHEAD` when the tag is nonzero (transition FREE→AHEAD) and to `CTX_WAIT` when the tag is zero (FREE→WAIT). In `CTX_AHEAD`, every issue decrements the counter. A memory issue there replaces the counter with the smaller of the decremented value and its own tag. When the counter reaches zero while references are still outstanding, the context moves to `CTX_WAIT` (AHEAD→WAIT). From either `CTX_AHEAD` or `CTX_WAIT`, the context returns to `CTX_FREE` when its last outstanding reference completes (AHEAD→FREE, WAIT→FREE). Among eligible contexts the choice is round-robin, starting just after the context issued most recently. The issue decision is registered, so it appears on the outputs one clock after the inputs that caused it.

Top module: `sched_top`

## Requirements
- R1: While reset is held, and in the cycle after it, `iss_valid` is 0. After reset every context is in `CTX_FREE` with no references outstanding and the round-robin pointer at context 0.
- R2: At most one context issues per cycle. The issued context had `ctx_ready` high in the cycle the decision was made.
- R3: Two issues from the same context are at least SPACING (16) cycles apart. With only one context ready, a stream of non-memory instructions issues exactly every 16 cycles.
- R4: The search for the next context begins at the context after the one issued most recently and wraps from NCTX-1 to 0.
- R5: Whenever at least one context is eligible, an issue appears in the next cycle. With 16 contexts continuously ready, every cycle issues. With 15, every 16th cycle is empty.
- R6: A memory issue (`head_mem`=1) from `CTX_FREE` sets the lookahead to its tag (`head_tag` bits [3c+2:3c] for context c). Each later issue from that context decrements the count, and at zero with references outstanding the context stops issuing.
- R7: A memory issue made while a reference of the same context is outstanding sets the lookahead to min(current count − 1, own tag).
- R8: A blocked context issues again one cycle after the completion (`cmp_valid` with `cmp_ctx`=c) that leaves it with no outstanding references. Completions for other contexts leave it blocked.
- R9: A memory instruction with tag 0 blocks its context immediately after it issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_ready | input | NCTX | Context c has an instruction waiting |
| head_mem | input | NCTX | Waiting instruction of context c is a memory reference |
| head_tag | input | NCTX*TAGW | Lookahead tag of context c's waiting instruction, bits [TAGW*c +: TAGW] |
| cmp_valid | input | 1 | A memory reference completes this cycle |
| cmp_ctx | input | $clog2(NCTX) | Context owning the completing reference |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_ctx | output | $clog2(NCTX) | Context that issues |

## Verification
The bench first runs single-context non-memory streams to isolate spacing. Sixteen-context and fifteen-context groups then separate full-rate interleaving and wrap-around order from the one-bubble-per-round case. Memory streams with a 70-cycle completion model use tag sequences 2,2,2 then 5,1 then 0 then 7. Their issue gaps (16, 55, 71 cycles) show whether the lookahead is loaded, decremented, reduced by the minimum rule, or ignored. Two contexts blocked one cycle apart show that a completion releases only its own context.

// File: rtl/tsched_pkg.sv
package tsched_pkg;

    typedef enum logic [1:0] {
        CTX_FREE  = 2'd0,
        CTX_AHEAD = 2'd1,
        CTX_WAIT  = 2'd2
    } ctx_st_e;

endpackage

// File: rtl/ctx_slot.sv
module ctx_slot
    import tsched_pkg::*;
#(
    parameter int SPACING = 16,
    parameter int TAGW    = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ready,
    input  logic            head_mem,
    input  logic [TAGW-1:0] head_tag,
    input  logic            grant,
    input  logic            cmp_hit,
    output logic            elig,
    output logic            blocked
);

    localparam int GAPW  = $clog2(SPACING + 1);
    localparam int PENDW = $clog2((2 ** TAGW) + 2);

    ctx_st_e          st_q, st_n;
    logic [GAPW-1:0]  gap_q;
    logic [TAGW-1:0]  la_q, la_n, la_dec;
    logic [PENDW-1:0] pend_q, pend_n;
    logic             issue_mem, retire;

    assign issue_mem = grant & head_mem;
    assign retire    = cmp_hit & (pend_q != '0);
    assign la_dec    = (la_q != '0) ? la_q - 1'b1 : '0;

    always_comb begin
        pend_n = pend_q + PENDW'(issue_mem) - PENDW'(retire);
    end

    // next state and lookahead
    always_comb begin
        st_n = st_q;
        la_n = la_q;
        unique case (st_q)
            CTX_FREE: begin
                if (issue_mem) begin
                    la_n = head_tag;
                    st_n = (head_tag == '0) ? CTX_WAIT : CTX_AHEAD;
                end
            end
            CTX_AHEAD: begin
                if (grant) begin
                    if (issue_mem)
                        la_n = (la_dec < head_tag) ? la_dec : head_tag;
                    else
                        la_n = la_dec;
                end
                if (pend_n == '0)
                    st_n = CTX_FREE;
                else if (la_n == '0)
                    st_n = CTX_WAIT;
            end
            CTX_WAIT: begin
                if (pend_n == '0)
                    st_n = CTX_FREE;
            end
            default: st_n = CTX_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CTX_FREE;
            la_q   <= '0;
            pend_q <= '0;
            gap_q  <= '0;
        end else begin
            st_q   <= st_n;
            la_q   <= la_n;
            pend_q <= pend_n;
            if (grant)
                gap_q <= GAPW'(SPACING - 1);
            else if (gap_q != '0)
                gap_q <= gap_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        blocked = (st_q == CTX_WAIT);
        elig    = ready && (gap_q == '0) && !blocked;
    end

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N    = 128,
    parameter int IDXW = $clog2(N)
) (
    input  logic [N-1:0]    req,
    input  logic [IDXW-1:0] ptr,
    output logic            found,
    output logic [IDXW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(ptr) + k;
            if (j >= N)
                j = j - N;
            if (!found && req[j]) begin
                found = 1'b1;
                idx   = IDXW'(j);
            end
        end
    end

endmodule

// File: rtl/sched_top.sv
module sched_top #(
    parameter int NCTX    = 128,
    parameter int SPACING = 16,
    parameter int TAGW    = 3,
    parameter int IDXW    = $clog2(NCTX)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCTX-1:0]      ctx_ready,
    input  logic [NCTX-1:0]      head_mem,
    input  logic [NCTX*TAGW-1:0] head_tag,
    input  logic                 cmp_valid,
    input  logic [IDXW-1:0]      cmp_ctx,
    output logic                 iss_valid,
    output logic [IDXW-1:0]      iss_ctx
);

    logic [NCTX-1:0] elig;
    logic [NCTX-1:0] blocked;
    logic [NCTX-1:0] gnt_vec;
    logic [IDXW-1:0] ptr_q;
    logic [IDXW-1:0] pick;
    logic            found;

    rr_pick #(.N(NCTX), .IDXW(IDXW)) u_pick (
        .req   (elig),
        .ptr   (ptr_q),
        .found (found),
        .idx   (pick)
    );

    for (genvar i = 0; i < NCTX; i++) begin : g_slot
        assign gnt_vec[i] = found && (pick == IDXW'(i));
        ctx_slot #(.SPACING(SPACING), .TAGW(TAGW)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .ready    (ctx_ready[i]),
            .head_mem (head_mem[i]),
            .head_tag (head_tag[i*TAGW +: TAGW]),
            .grant    (gnt_vec[i]),
            .cmp_hit  (cmp_valid && (cmp_ctx == IDXW'(i))),
            .elig     (elig[i]),
            .blocked  (blocked[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iss_valid <= 1'b0;
            iss_ctx   <= '0;
            ptr_q     <= '0;
        end else begin
            iss_valid <= found;
            if (found) begin
                iss_ctx <= pick;
                ptr_q   <= (pick == IDXW'(NCTX - 1)) ? '0 : pick + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
    parameter int NCTX    = 128,
    parameter int SPACING = 16,
    parameter int IDXW    = $clog2(NCTX)
) (
    input logic            clk,
    input logic            rst,
    input logic [NCTX-1:0] ctx_ready,
    input logic [NCTX-1:0] elig,
    input logic [NCTX-1:0] blocked,
    input logic            iss_valid,
    input logic [IDXW-1:0] iss_ctx
);

    localparam int SW = $clog2(SPACING + 1);

    logic [NCTX-1:0] rdy_q;
    logic [NCTX-1:0] blk_q;
    logic [SW-1:0]   since_q [NCTX];

    always_ff @(posedge clk) begin
        rdy_q <= ctx_ready;
        blk_q <= blocked;
        for (int c = 0; c < NCTX; c++) begin
            if (rst)
                since_q[c] <= SW'(SPACING - 1);
            else if (iss_valid && (iss_ctx == IDXW'(c)))
                since_q[c] <= '0;
            else if (since_q[c] != SW'(SPACING - 1))
                since_q[c] <= since_q[c] + 1'b1;
        end
    end

    assert_idle_in_reset_R1: assert property (@(posedge clk)
        rst |=> !iss_valid);

    assert_issue_was_ready_R2: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> rdy_q[iss_ctx]);

    assert_min_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (since_q[iss_ctx] >= SW'(SPACING - 1)));

    assert_no_idle_slot_R5: assert property (@(posedge clk) disable iff (rst)
        (|elig) |=> iss_valid);

    assert_blocked_silent_R6: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> !blk_q[iss_ctx]);

endmodule

bind sched_top sched_chk #(.NCTX(NCTX), .SPACING(SPACING), .IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctx_ready (ctx_ready),
    .elig      (elig),
    .blocked   (blocked),
    .iss_valid (iss_valid),
    .iss_ctx   (iss_ctx)
);

// File: tb/sim_sched_top.sv
module sim_sched_top;

    localparam int NC  = 128;
    localparam int IW  = 7;
    localparam int LAT = 70;

    logic            clk = 1'b0;
    logic            rst;
    logic [NC-1:0]   ctx_ready;
    logic [NC-1:0]   head_mem;
    logic [NC*3-1:0] head_tag;
    logic            cmp_valid;
    logic [IW-1:0]   cmp_ctx;
    logic            iss_valid;
    logic [IW-1:0]   iss_ctx;

    always #10 clk = ~clk;

    sched_top u0 (
        .clk       (clk),
        .rst       (rst),
        .ctx_ready (ctx_ready),
        .head_mem  (head_mem),
        .head_tag  (head_tag),
        .cmp_valid (cmp_valid),
        .cmp_ctx   (cmp_ctx),
        .iss_valid (iss_valid),
        .iss_ctx   (iss_ctx)
    );

    // instruction programs per context
    logic       pm [NC][8];
    logic [2:0] pt [NC][8];
    int         plen [NC];
    int         pidx [NC];
    int         last_c [NC];
    int         last_g;
    int         cyc = 0;
    int         total = 0;
    int         bad = 0;

    int eq_c[$];
    int eq_cg[$];
    int eq_gg[$];
    int mq_t[$];
    int mq_c[$];

    always @(posedge clk) cyc <= cyc + 1;

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            int k;
            k = (pidx[c] < 8) ? pidx[c] : 0;
            ctx_ready[c]       = (pidx[c] < plen[c]);
            head_mem[c]        = pm[c][k];
            head_tag[c*3 +: 3] = pt[c][k];
        end
    end

    task automatic clr();
        for (int c = 0; c < NC; c++) begin
            plen[c]   = 0;
            pidx[c]   = 0;
            last_c[c] = -1;
            for (int k = 0; k < 8; k++) begin
                pm[c][k] = 1'b0;
                pt[c][k] = 3'd0;
            end
        end
        last_g = -1;
    endtask

    task automatic put(input int c, input int k, input logic m, input int t);
        pm[c][k] = m;
        pt[c][k] = 3'(t);
        if (plen[c] < k + 1) plen[c] = k + 1;
    endtask

    // driver side of the scoreboard
    task automatic expect_issue(input int c, input int cg, input int gg);
        eq_c.push_back(c);
        eq_cg.push_back(cg);
        eq_gg.push_back(gg);
    endtask

    task automatic fail_line(input string req, input string what, input int act, input int exp);
        bad++;
        $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    endtask

    // monitor and memory model, called once per negative edge
    task automatic step();
        if (iss_valid) begin
            int c, ec, ecg, egg;
            c = int'(iss_ctx);
            total++;
            if (eq_c.size() == 0) begin
                fail_line("R2", "unexpected issue ctx", c, -1);
            end else begin
                ec  = eq_c.pop_front();
                ecg = eq_cg.pop_front();
                egg = eq_gg.pop_front();
                if (c != ec)
                    fail_line("R4", "issue ctx", c, ec);
                else if (ecg >= 0 && (cyc - last_c[c]) != ecg)
                    fail_line("R3/R6/R7/R8", "ctx gap", cyc - last_c[c], ecg);
                else if (egg >= 0 && (cyc - last_g) != egg)
                    fail_line("R5", "global gap", cyc - last_g, egg);
            end
            if (pidx[c] < 8 && pm[c][pidx[c]]) begin
                mq_t.push_back(cyc + LAT);
                mq_c.push_back(c);
            end
            pidx[c]   = pidx[c] + 1;
            last_c[c] = cyc;
            last_g    = cyc;
        end
        cmp_valid = 1'b0;
        cmp_ctx   = '0;
        for (int i = 0; i < mq_t.size(); i++) begin
            if (mq_t[i] == cyc + 1) begin
                cmp_valid = 1'b1;
                cmp_ctx   = IW'(mq_c[i]);
                mq_t.delete(i);
                mq_c.delete(i);
                break;
            end
        end
    endtask

    task automatic run_scn(input string name);
        int n;
        n = 0;
        while (eq_c.size() > 0 && n < 600) begin
            @(negedge clk);
            step();
            n++;
        end
        total++;
        if (eq_c.size() > 0) begin
            fail_line("R5", {name, " missing issues"}, 0, eq_c.size());
            eq_c.delete();
            eq_cg.delete();
            eq_gg.delete();
        end
        repeat (90) begin
            @(negedge clk);
            step();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        cmp_valid = 1'b0;
        cmp_ctx   = '0;
        clr();
        repeat (5) @(negedge clk);
        total++;
        if (iss_valid !== 1'b0) fail_line("R1", "iss_valid in reset", int'(iss_valid), 0);
        rst = 1'b0;
        repeat (3) begin @(negedge clk); step(); end
        total++;
        if (iss_valid !== 1'b0) fail_line("R1", "iss_valid after reset", int'(iss_valid), 0);

        // R3: lone context, plain instructions
        clr();
        for (int k = 0; k < 3; k++) put(7, k, 1'b0, 0);
        expect_issue(7, -1, -1); expect_issue(7, 16, -1); expect_issue(7, 16, -1);
        run_scn("spacing");

        // R4 R5: sixteen contexts fill every slot, pointer starts at 8
        clr();
        for (int c = 0; c < 16; c++) begin put(c, 0, 1'b0, 0); put(c, 1, 1'b0, 0); end
        for (int r = 0; r < 2; r++)
            for (int k = 0; k < 16; k++)
                expect_issue((8 + k) % 16, (r == 0) ? -1 : 16, (r == 0 && k == 0) ? -1 : 1);
        run_scn("fill16");

        // R5: fifteen contexts leave one empty slot per round
        clr();
        for (int c = 0; c < 15; c++) begin put(c, 0, 1'b0, 0); put(c, 1, 1'b0, 0); end
        for (int k = 0; k < 15; k++) expect_issue((8 + k) % 15, -1, (k == 0) ? -1 : 1);
        for (int k = 0; k < 15; k++) expect_issue((8 + k) % 15, 16, (k == 0) ? 2 : 1);
        run_scn("fill15");

        // R6 R7: tags 2,2,2 exhaust the lookahead after the third reference
        clr();
        put(3, 0, 1'b1, 2); put(3, 1, 1'b1, 2); put(3, 2, 1'b1, 2);
        put(3, 3, 1'b0, 0); put(3, 4, 1'b0, 0);
        expect_issue(3, -1, -1); expect_issue(3, 16, -1); expect_issue(3, 16, -1);
        expect_issue(3, 71, -1); expect_issue(3, 16, -1);
        run_scn("lookahead");

        // R7: smaller own tag replaces remaining count
        clr();
        put(40, 0, 1'b1, 5); put(40, 1, 1'b1, 1); put(40, 2, 1'b0, 0); put(40, 3, 1'b0, 0);
        expect_issue(40, -1, -1); expect_issue(40, 16, -1); expect_issue(40, 16, -1);
        expect_issue(40, 55, -1);
        run_scn("minrule");

        // R9: tag zero blocks at once
        clr();
        put(60, 0, 1'b1, 0); put(60, 1, 1'b0, 0);
        expect_issue(60, -1, -1); expect_issue(60, 71, -1);
        run_scn("tag0");

        // R6: tag seven lets the context run on until completion
        clr();
        put(61, 0, 1'b1, 7);
        for (int k = 1; k < 5; k++) put(61, k, 1'b0, 0);
        expect_issue(61, -1, -1);
        for (int k = 1; k < 5; k++) expect_issue(61, 16, -1);
        run_scn("runahead");

        // R8: completions release only their own context
        clr();
        put(80, 0, 1'b1, 0); put(80, 1, 1'b0, 0);
        put(81, 0, 1'b1, 0); put(81, 1, 1'b0, 0);
        expect_issue(80, -1, -1); expect_issue(81, -1, 1);
        expect_issue(80, 71, 70); expect_issue(81, 71, 1);
        run_scn("isolation");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule